// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts the targets of subroutine returns in the decode stage of a RISC-V pipeline. Each cycle the decoder presents one instruction's major opcode, destination and first source register numbers, and its PC. Jumps that follow the calling convention, meaning they write the link register x1, save their fall-through address on a small stack. A register-indirect jump that reads x1 and discards its own link result is treated as a return. For a return the block gives the saved address as a predicted next PC and removes that entry from the stack.

The stack is a circular buffer with an occupancy counter. When it is full, a new call overwrites the oldest saved address instead of stalling decode. A return seen while the stack is empty produces no prediction. Instructions that the pipeline has marked as wrong-path, and decode slots that carry no instruction, leave the stack as it is. Repairing the stack after a misprediction is left to the surrounding pipeline.

Top module: `ras_predictor`

## Requirements
- R1: A valid, unkilled JAL (opcode 7'b1101111) with rd = 1 pushes its PC + 4 onto the stack and gives no prediction.
- R2: A valid, unkilled JALR (opcode 7'b1100111) with rd = 1, whatever rs1 holds, pushes its PC + 4 and gives no prediction.
- R3: A valid, unkilled JALR with rd = 0 and rs1 = 1 on a non-empty stack drives pred_valid high and pred_target to the most recently pushed address that has not yet been removed, in the same cycle. That entry is removed at the next clock edge.
- R4: Any other instruction pushes nothing, pops nothing and gives no prediction. This covers a JAL with rd = 0, a JALR with rd = 0 and rs1 other than 1, and a non-jump opcode with rd = 1.
- R5: A return on an empty stack gives pred_valid low and leaves the stack unchanged. pred_target is zero whenever pred_valid is low.
- R6: The stack holds DEPTH (default 8) entries. A push when it is full drops the oldest entry, so DEPTH returns then give the DEPTH newest addresses, newest first, and the next return gives no prediction.
- R7: When dec_valid is low or dec_kill is high, the instruction neither changes the stack nor produces a prediction.
- R8: Synchronous active-high reset empties the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_kill | input | 1 | Instruction is on a wrong path (stale epoch) |
| dec_opcode | input | 7 | Major opcode field of the instruction |
| dec_rd | input | 5 | Destination register number |
| dec_rs1 | input | 5 | First source register number |
| dec_pc | input | XLEN | PC of the instruction |
| pred_valid | output | 1 | A return target prediction is present |
| pred_target | output | XLEN | Predicted return address, zero when not valid |

## Verification
The bench targets the classification boundaries. A JAL that discards its link, a JALR that reads a register other than x1, and a non-jump opcode that writes x1 must all leave the stack alone. A classifier that tested only rd, or only the opcode, would push or pop on these instructions and later returns would show the wrong addresses. A return on an empty stack must give nothing: a design that let the pointer or count underflow would later return stale addresses. Killed and empty decode slots are placed between pushes and pops, so that a design that ignored the epoch would show up as a shifted return sequence. The bench also overflows the stack by two entries. A design with wrong wrap or count saturation would either return the dropped oldest addresses or run out of entries too early.

// File: rtl/ras_pkg.sv
package ras_pkg;

    localparam logic [6:0] OPC_JAL  = 7'b1101111;
    localparam logic [6:0] OPC_JALR = 7'b1100111;
    localparam logic [4:0] REG_ZERO = 5'd0;
    localparam logic [4:0] REG_LINK = 5'd1;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_PUSH = 2'd1,
        ACT_POP  = 2'd2
    } ras_act_e;

    typedef struct packed {
        logic [6:0] opcode;
        logic [4:0] rd;
        logic [4:0] rs1;
    } ras_fields_t;

    function automatic ras_act_e ras_classify_fn(ras_fields_t f);
        ras_act_e a;
        a = ACT_NONE;
        if ((f.opcode == OPC_JAL || f.opcode == OPC_JALR) && f.rd == REG_LINK)
            a = ACT_PUSH;
        else if (f.opcode == OPC_JALR && f.rd == REG_ZERO && f.rs1 == REG_LINK)
            a = ACT_POP;
        return a;
    endfunction

endpackage

// File: rtl/ras_classify.sv
module ras_classify
    import ras_pkg::*;
(
    input  logic        slot_valid,
    input  logic        slot_kill,
    input  ras_fields_t fields,
    output ras_act_e    act
);
    always_comb begin
        if (slot_valid && !slot_kill)
            act = ras_classify_fn(fields);
        else
            act = ACT_NONE;
    end
endmodule

// File: rtl/ras_stack.sv
module ras_stack #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    input  logic [XLEN-1:0] push_data,
    output logic [XLEN-1:0] top_data,
    output logic [OW-1:0]   occ,
    output logic [IW-1:0]   top_idx
);
    localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);
    localparam logic [OW-1:0] FULL_OCC = OW'(DEPTH);

    logic [XLEN-1:0] slot_q [DEPTH];
    logic [IW-1:0]   inc_idx;
    logic [IW-1:0]   dec_idx;

    assign inc_idx  = (top_idx == LAST_IDX) ? '0 : top_idx + 1'b1;
    assign dec_idx  = (top_idx == '0) ? LAST_IDX : top_idx - 1'b1;
    assign top_data = slot_q[top_idx];

    // Each slot is written only by a push that lands on it; a full-stack
    // push lands on the oldest slot and thereby drops it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[i] <= '0;
            else if (push && inc_idx == IW'(i))
                slot_q[i] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_idx <= LAST_IDX;
            occ     <= '0;
        end else if (push) begin
            top_idx <= inc_idx;
            if (occ != FULL_OCC)
                occ <= occ + 1'b1;
        end else if (pop) begin
            top_idx <= dec_idx;
            occ     <= occ - 1'b1;
        end
    end
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
    import ras_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dec_valid,
    input  logic            dec_kill,
    input  logic [6:0]      dec_opcode,
    input  logic [4:0]      dec_rd,
    input  logic [4:0]      dec_rs1,
    input  logic [XLEN-1:0] dec_pc,
    output logic            pred_valid,
    output logic [XLEN-1:0] pred_target
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OW = $clog2(DEPTH + 1);

    ras_fields_t     fields;
    ras_act_e        act;
    logic            push_en;
    logic            pop_en;
    logic [XLEN-1:0] link_addr;
    logic [XLEN-1:0] top_data;
    logic [OW-1:0]   occ;
    logic [IW-1:0]   top_idx;

    assign fields    = '{opcode: dec_opcode, rd: dec_rd, rs1: dec_rs1};
    assign link_addr = dec_pc + XLEN'(4);

    ras_classify u_classify (
        .slot_valid (dec_valid),
        .slot_kill  (dec_kill),
        .fields     (fields),
        .act        (act)
    );

    assign push_en = (act == ACT_PUSH);
    assign pop_en  = (act == ACT_POP) && (occ != '0);

    ras_stack #(.XLEN(XLEN), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (push_en),
        .pop       (pop_en),
        .push_data (link_addr),
        .top_data  (top_data),
        .occ       (occ),
        .top_idx   (top_idx)
    );

    assign pred_valid  = pop_en;
    assign pred_target = pop_en ? top_data : '0;
endmodule

// File: rtl/ras_predictor_chk.sv
module ras_predictor_chk #(
    parameter int DEPTH = 8,
    parameter int IW    = 3,
    parameter int OW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          dec_valid,
    input logic          dec_kill,
    input logic          push_en,
    input logic          pred_valid,
    input logic [OW-1:0] occ,
    input logic [IW-1:0] top_idx
);
    assert_occ_cap_R6: assert property (@(posedge clk) disable iff (rst)
        occ <= OW'(DEPTH));

    assert_empty_no_pred_R5: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> !pred_valid);

    assert_pop_shrinks_R3: assert property (@(posedge clk) disable iff (rst)
        pred_valid |=> (occ == $past(occ) - 1'b1));

    assert_push_grows_R1: assert property (@(posedge clk) disable iff (rst)
        (push_en && occ != OW'(DEPTH)) |=> (occ == $past(occ) + 1'b1));

    assert_full_push_stays_full_R6: assert property (@(posedge clk) disable iff (rst)
        (push_en && occ == OW'(DEPTH)) |=> (occ == OW'(DEPTH)));

    assert_kill_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (!dec_valid || dec_kill) |=> ($stable(occ) && $stable(top_idx)));
endmodule

bind ras_predictor ras_predictor_chk #(
    .DEPTH (DEPTH),
    .IW    (IW),
    .OW    (OW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dec_valid  (dec_valid),
    .dec_kill   (dec_kill),
    .push_en    (push_en),
    .pred_valid (pred_valid),
    .occ        (occ),
    .top_idx    (top_idx)
);

// File: tb/ras_predictor_tb.sv
module ras_predictor_tb;
    import ras_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN  = 32;
    localparam int DEPTH = 8;
    localparam int NVEC  = 16;
    localparam logic [6:0] OPC_ADDI = 7'b0010011;

    // {valid, kill, opcode, rd, rs1, pc, exp_valid, exp_target}
    localparam logic [83:0] VEC [NVEC] = '{
        {1'b1, 1'b0, OPC_JALR, 5'd0, 5'd1, 32'h0000_0100, 1'b0, 32'h0},           // R5 empty return
        {1'b1, 1'b0, OPC_JAL,  5'd1, 5'd0, 32'h0000_1000, 1'b0, 32'h0},           // R1 push 1004
        {1'b1, 1'b0, OPC_JALR, 5'd1, 5'd5, 32'h0000_2000, 1'b0, 32'h0},           // R2 push 2004
        {1'b1, 1'b0, OPC_JAL,  5'd0, 5'd0, 32'h0000_3000, 1'b0, 32'h0},           // R4 plain jump
        {1'b1, 1'b0, OPC_JALR, 5'd0, 5'd1, 32'h0000_4000, 1'b1, 32'h0000_2004},   // R3
        {1'b1, 1'b1, OPC_JALR, 5'd0, 5'd1, 32'h0000_4100, 1'b0, 32'h0},           // R7 killed
        {1'b0, 1'b0, OPC_JALR, 5'd0, 5'd1, 32'h0000_4180, 1'b0, 32'h0},           // R7 empty slot
        {1'b1, 1'b0, OPC_JALR, 5'd0, 5'd1, 32'h0000_4200, 1'b1, 32'h0000_1004},   // R3
        {1'b1, 1'b0, OPC_JALR, 5'd0, 5'd1, 32'h0000_4300, 1'b0, 32'h0},           // R5 empty again
        {1'b1, 1'b0, OPC_JALR, 5'd0, 5'd2, 32'h0000_4400, 1'b0, 32'h0},           // R4 other rs1
        {1'b1, 1'b1, OPC_JAL,  5'd1, 5'd0, 32'h0000_5000, 1'b0, 32'h0},           // R7 killed call
        {1'b1, 1'b0, OPC_JALR, 5'd0, 5'd1, 32'h0000_5100, 1'b0, 32'h0},           // R7 nothing pushed
        {1'b1, 1'b0, OPC_JAL,  5'd1, 5'd0, 32'h0000_6000, 1'b0, 32'h0},           // R1 push 6004
        {1'b1, 1'b0, OPC_ADDI, 5'd1, 5'd1, 32'h0000_7000, 1'b0, 32'h0},           // R4 non-jump
        {1'b1, 1'b0, OPC_JALR, 5'd0, 5'd1, 32'h0000_7100, 1'b1, 32'h0000_6004},   // R4 R3
        {1'b1, 1'b0, OPC_JALR, 5'd0, 5'd1, 32'h0000_7200, 1'b0, 32'h0}            // R4 R5
    };

    logic            clk = 1'b0;
    logic            rst;
    logic            dec_valid;
    logic            dec_kill;
    logic [6:0]      dec_opcode;
    logic [4:0]      dec_rd;
    logic [4:0]      dec_rs1;
    logic [XLEN-1:0] dec_pc;
    logic            pred_valid;
    logic [XLEN-1:0] pred_target;

    int tests_run = 0;
    int tests_failed = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ras_predictor #(.XLEN(XLEN), .DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .dec_valid   (dec_valid),
        .dec_kill    (dec_kill),
        .dec_opcode  (dec_opcode),
        .dec_rd      (dec_rd),
        .dec_rs1     (dec_rs1),
        .dec_pc      (dec_pc),
        .pred_valid  (pred_valid),
        .pred_target (pred_target)
    );

    task automatic check(input string req, input logic ev, input logic [XLEN-1:0] et);
        tests_run++;
        if (pred_valid !== ev || pred_target !== et) begin
            tests_failed++;
            $display("FAIL %s: got valid=%0b target=%h, expected valid=%0b target=%h",
                     req, pred_valid, pred_target, ev, et);
        end
    endtask

    // Drive at the falling edge, sample the same-cycle prediction, then let
    // the next rising edge commit the update.
    task automatic step(input logic v, input logic k, input logic [6:0] opc,
                        input logic [4:0] rd, input logic [4:0] rs1,
                        input logic [XLEN-1:0] pc, input string req,
                        input logic ev, input logic [XLEN-1:0] et);
        dec_valid = v; dec_kill = k; dec_opcode = opc;
        dec_rd = rd; dec_rs1 = rs1; dec_pc = pc;
        #1;
        check(req, ev, et);
        @(negedge clk);
    endtask

    task automatic call_at(input logic [XLEN-1:0] pc, input string req);
        step(1'b1, 1'b0, OPC_JAL, REG_LINK, 5'd0, pc, req, 1'b0, '0);
    endtask

    task automatic ret_at(input logic [XLEN-1:0] pc, input string req,
                          input logic ev, input logic [XLEN-1:0] et);
        step(1'b1, 1'b0, OPC_JALR, REG_ZERO, REG_LINK, pc, req, ev, et);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        tests_failed++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        rst = 1'b1;
        dec_valid = 1'b0; dec_kill = 1'b0; dec_opcode = '0;
        dec_rd = '0; dec_rs1 = '0; dec_pc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8 reset state: a return right after reset predicts nothing
        ret_at(32'h10, "R8", 1'b0, '0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][83], VEC[i][82], VEC[i][81:75], VEC[i][74:70], VEC[i][69:65],
                 VEC[i][64:33], $sformatf("vec%0d R1-R7 table", i), VEC[i][32], VEC[i][31:0]);
        end

        // R6 overflow: ten calls, the two oldest are dropped
        for (int i = 1; i <= DEPTH + 2; i++)
            call_at(XLEN'(i * 32'h100), "R6 push");
        for (int i = DEPTH + 2; i >= 3; i--)
            ret_at(32'h9000, "R6 lifo after overflow", 1'b1, XLEN'(i * 32'h100 + 4));
        ret_at(32'h9000, "R6 oldest dropped", 1'b0, '0);

        // R2 JALR call with rs1 = x1 still pushes
        step(1'b1, 1'b0, OPC_JALR, REG_LINK, REG_LINK, 32'hA000, "R2", 1'b0, '0);
        ret_at(32'hA100, "R2 pop", 1'b1, 32'hA004);

        // R8 reset empties a populated stack
        call_at(32'hB000, "R8 push");
        call_at(32'hB100, "R8 push");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ret_at(32'hB200, "R8 after reset", 1'b0, '0);

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule